// File: doc/BRIEF.md
# High-Speed Burst Sequencer for One Data Lane

This block steers a single data lane of a serial display or camera link through one high-speed burst. From the idle stop level it signals a request, then a bridge level, then holds the high-speed zero state, emits a fixed sync byte and streams payload bytes accepted from a byte source through a valid/ready handshake. When the payload ends it drives a trail state and then returns the lane to the stop level for an exit interval. Only after that interval can a new burst start.

Every interval is a cycle count presented on a configuration input, so firmware can derive the counts from the link bit rate. The outputs are a two-bit line-state code, a byte and a byte-valid flag. A downstream serializer turns these into wire levels. The block does no serialization and produces no analog levels. It has no clock-lane control.

Top module: `hs_lane_seq`

## Requirements
- R1: After reset the lane code is 2'b11 (stop), `lane_bvld` is 0, `lane_byte` is 0 and `src_ready` is 0.
- R2: In idle, a burst starts only on a cycle where `start` and `clk_rdy` are both 1. Otherwise the lane stays at code 2'b11.
- R3: After a start, the lane shows code 2'b01 for max(`cfg_lpx`,1) cycles and then code 2'b00 for max(`cfg_prep`,1) cycles.
- R4: Next the lane shows code 2'b10 with `lane_byte` 8'h00 and `lane_bvld` 1 for max(`cfg_zero`,1) cycles. It then shows code 2'b10 with byte 8'hB8 for exactly one cycle.
- R5: `src_ready` is 1 during the sync cycle and during payload cycles until a byte flagged `src_last` has been taken. A byte taken on a clock edge (valid and ready both 1) appears on `lane_byte` with `lane_bvld` 1 in the cycle after that edge.
- R6: The payload ends after the byte taken with `src_last` 1, or earlier when `src_valid` is 0 while `src_ready` is 1. The following cycle is the first trail cycle.
- R7: During the trail, every bit of `lane_byte` equals the inverse of bit 7, the last bit to be serialized, of the final byte sent. If no payload byte was sent, that final byte is the sync byte, so the trail byte is 8'h00.
- R8: The trail lasts max(`cfg_trail`,1) cycles with code 2'b10. The lane then shows code 2'b11 for max(`cfg_exit`,1) cycles. `start` is ignored throughout the trail and the exit, and the block is idle again in the cycle after the exit.
- R9: Whenever the lane code is not 2'b10, `lane_bvld` is 0 and `lane_byte` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Burst request |
| clk_rdy | input | 1 | Clock lane is running in high-speed mode |
| cfg_lpx | input | CW | Request (LP-01) length in cycles |
| cfg_prep | input | CW | Bridge (LP-00) length in cycles |
| cfg_zero | input | CW | HS-0 length in cycles |
| cfg_trail | input | CW | Trail length in cycles |
| cfg_exit | input | CW | Exit stop length in cycles |
| src_valid | input | 1 | Payload byte available |
| src_data | input | DW | Payload byte |
| src_last | input | 1 | Marks the final payload byte |
| src_ready | output | 1 | Payload byte is taken this cycle if valid |
| lane_code | output | 2 | Line state: 11 stop, 01 request, 00 bridge, 10 high speed |
| lane_byte | output | DW | Byte for the serializer |
| lane_bvld | output | 1 | `lane_byte` is meaningful |

## Verification
A wrong phase or a counter that is off by one changes `lane_code` or `lane_byte` in the very cycle it occurs. The bench therefore compares every cycle of each burst with a sequence it builds from the configured counts. A stale trail bit or a lost payload byte shows as a wrong `lane_byte` during the trail, or during the payload cycle after the byte was taken. A handshake fault shows as a missing or extra payload cycle, and that shifts every later expected value. Premature starts show as a code 2'b01 in a cycle where 2'b11 was due.

// File: rtl/hs_lane_pkg.sv
package hs_lane_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_REQ,
        PH_PREP,
        PH_ZERO,
        PH_SYNC,
        PH_PAYLD,
        PH_TRAIL,
        PH_EXIT
    } lane_phase_e;

    // Line codes mirror the two single-ended levels; 2'b10 marks high-speed drive.
    localparam logic [1:0] LINE_STOP   = 2'b11;
    localparam logic [1:0] LINE_REQ    = 2'b01;
    localparam logic [1:0] LINE_BRIDGE = 2'b00;
    localparam logic [1:0] LINE_HS     = 2'b10;

    localparam logic [7:0] SYNC_PATTERN = 8'hB8;

endpackage

// File: rtl/hs_lane_ctrl.sv
module hs_lane_ctrl
    import hs_lane_pkg::*;
#(
    parameter int CW = 8,
    parameter int DW = 8,
    parameter logic [DW-1:0] SYNC_BYTE = SYNC_PATTERN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          clk_rdy,
    input  logic [CW-1:0] cfg_lpx,
    input  logic [CW-1:0] cfg_prep,
    input  logic [CW-1:0] cfg_zero,
    input  logic [CW-1:0] cfg_trail,
    input  logic [CW-1:0] cfg_exit,
    input  logic          src_valid,
    input  logic [DW-1:0] src_data,
    input  logic          src_last,
    output logic          src_ready,
    output lane_phase_e   phase,
    output logic [DW-1:0] cur_byte,
    output logic          tail_bit
);

    typedef struct packed {
        lane_phase_e   phase;
        logic [CW-1:0] cnt;
        logic [DW-1:0] data;
        logic          tail;
        logic          end_seen;
    } seq_st_t;

    seq_st_t st_d, st_q;

    // A programmed count of zero still yields one cycle.
    function automatic logic [CW-1:0] span(input logic [CW-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    assign src_ready = (st_q.phase == PH_SYNC) ||
                       (st_q.phase == PH_PAYLD && !st_q.end_seen);

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start && clk_rdy) begin
                    st_d.phase = PH_REQ;
                    st_d.cnt   = span(cfg_lpx);
                end
            end
            PH_REQ: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_PREP;
                    st_d.cnt   = span(cfg_prep);
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_PREP: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_ZERO;
                    st_d.cnt   = span(cfg_zero);
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_ZERO: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_SYNC;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_SYNC: begin
                if (src_valid) begin
                    st_d.phase    = PH_PAYLD;
                    st_d.data     = src_data;
                    st_d.tail     = src_data[DW-1];
                    st_d.end_seen = src_last;
                end else begin
                    st_d.phase = PH_TRAIL;
                    st_d.cnt   = span(cfg_trail);
                    st_d.tail  = SYNC_BYTE[DW-1];
                end
            end
            PH_PAYLD: begin
                if (st_q.end_seen || !src_valid) begin
                    st_d.phase    = PH_TRAIL;
                    st_d.cnt      = span(cfg_trail);
                    st_d.end_seen = 1'b0;
                end else begin
                    st_d.data     = src_data;
                    st_d.tail     = src_data[DW-1];
                    st_d.end_seen = src_last;
                end
            end
            PH_TRAIL: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_EXIT;
                    st_d.cnt   = span(cfg_exit);
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_EXIT: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase    <= PH_IDLE;
            st_q.cnt      <= '0;
            st_q.data     <= '0;
            st_q.tail     <= 1'b0;
            st_q.end_seen <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase    = st_q.phase;
    assign cur_byte = st_q.data;
    assign tail_bit = st_q.tail;

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && !(start && clk_rdy)) |=> st_q.phase == PH_IDLE);

    assert_take_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ready && src_valid) |=> (st_q.phase == PH_PAYLD && st_q.data == $past(src_data)));

    assert_last_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ready && src_valid && src_last) |=> !src_ready);

    assert_underrun_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ready && !src_valid) |=> st_q.phase == PH_TRAIL);

    assert_exit_deaf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_EXIT) |=> (st_q.phase == PH_EXIT || st_q.phase == PH_IDLE));

endmodule

// File: rtl/hs_lane_drv.sv
module hs_lane_drv
    import hs_lane_pkg::*;
#(
    parameter int DW = 8,
    parameter logic [DW-1:0] SYNC_BYTE = SYNC_PATTERN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  lane_phase_e   phase,
    input  logic [DW-1:0] cur_byte,
    input  logic          tail_bit,
    output logic [1:0]    lane_code,
    output logic [DW-1:0] lane_byte,
    output logic          lane_bvld
);

    always_comb begin
        lane_code = LINE_STOP;
        lane_byte = '0;
        lane_bvld = 1'b0;
        unique case (phase)
            PH_REQ:   lane_code = LINE_REQ;
            PH_PREP:  lane_code = LINE_BRIDGE;
            PH_ZERO: begin
                lane_code = LINE_HS;
                lane_bvld = 1'b1;
            end
            PH_SYNC: begin
                lane_code = LINE_HS;
                lane_byte = SYNC_BYTE;
                lane_bvld = 1'b1;
            end
            PH_PAYLD: begin
                lane_code = LINE_HS;
                lane_byte = cur_byte;
                lane_bvld = 1'b1;
            end
            PH_TRAIL: begin
                lane_code = LINE_HS;
                lane_byte = {DW{~tail_bit}};
                lane_bvld = 1'b1;
            end
            default: lane_code = LINE_STOP;
        endcase
    end

    assert_lp_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_code != LINE_HS) |-> (!lane_bvld && lane_byte == '0));

    assert_trail_flat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TRAIL) |-> (lane_byte == '0 || lane_byte == '1));

endmodule

// File: rtl/hs_lane_seq.sv
module hs_lane_seq
    import hs_lane_pkg::*;
#(
    parameter int CW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          clk_rdy,
    input  logic [CW-1:0] cfg_lpx,
    input  logic [CW-1:0] cfg_prep,
    input  logic [CW-1:0] cfg_zero,
    input  logic [CW-1:0] cfg_trail,
    input  logic [CW-1:0] cfg_exit,
    input  logic          src_valid,
    input  logic [DW-1:0] src_data,
    input  logic          src_last,
    output logic          src_ready,
    output logic [1:0]    lane_code,
    output logic [DW-1:0] lane_byte,
    output logic          lane_bvld
);

    localparam logic [DW-1:0] SYNC_BYTE = DW'(SYNC_PATTERN);

    lane_phase_e   phase;
    logic [DW-1:0] cur_byte;
    logic          tail_bit;

    hs_lane_ctrl #(.CW(CW), .DW(DW), .SYNC_BYTE(SYNC_BYTE)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .clk_rdy   (clk_rdy),
        .cfg_lpx   (cfg_lpx),
        .cfg_prep  (cfg_prep),
        .cfg_zero  (cfg_zero),
        .cfg_trail (cfg_trail),
        .cfg_exit  (cfg_exit),
        .src_valid (src_valid),
        .src_data  (src_data),
        .src_last  (src_last),
        .src_ready (src_ready),
        .phase     (phase),
        .cur_byte  (cur_byte),
        .tail_bit  (tail_bit)
    );

    hs_lane_drv #(.DW(DW), .SYNC_BYTE(SYNC_BYTE)) u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .cur_byte  (cur_byte),
        .tail_bit  (tail_bit),
        .lane_code (lane_code),
        .lane_byte (lane_byte),
        .lane_bvld (lane_bvld)
    );

    assert_ready_in_hs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> (lane_code == LINE_HS && lane_bvld));

    assert_req_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_code == LINE_REQ) |=> (lane_code == LINE_REQ || lane_code == LINE_BRIDGE));

endmodule

// File: tb/hs_lane_seq_bench.sv
module hs_lane_seq_bench;
    localparam int CW = 8;
    localparam int DW = 8;
    localparam logic [1:0] C_STOP = 2'b11, C_REQ = 2'b01, C_BRG = 2'b00, C_HS = 2'b10;
    localparam logic [DW-1:0] SYNC_B = 8'hB8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, start, clk_rdy, src_valid, src_last;
    logic [CW-1:0] cfg_lpx, cfg_prep, cfg_zero, cfg_trail, cfg_exit;
    logic [DW-1:0] src_data;
    logic          src_ready, lane_bvld;
    logic [1:0]    lane_code;
    logic [DW-1:0] lane_byte;

    hs_lane_seq #(.CW(CW), .DW(DW)) u_hs_lane_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .clk_rdy(clk_rdy),
        .cfg_lpx(cfg_lpx), .cfg_prep(cfg_prep), .cfg_zero(cfg_zero),
        .cfg_trail(cfg_trail), .cfg_exit(cfg_exit),
        .src_valid(src_valid), .src_data(src_data), .src_last(src_last),
        .src_ready(src_ready), .lane_code(lane_code), .lane_byte(lane_byte),
        .lane_bvld(lane_bvld)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [DW-1:0] pl [16];
    int idx, n_cur;
    bit pend, last_en;

    function automatic int span(int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic [DW-1:0] trail_fill(logic b);
        return b ? '0 : '1;
    endfunction

    task automatic check(string tag, logic [1:0] ec, logic [DW-1:0] eb, logic ev);
        checks++;
        if (lane_code !== ec || lane_byte !== eb || lane_bvld !== ev) begin
            fails++;
            $display("FAIL %s t=%0t actual code=%b byte=%h vld=%b expected code=%b byte=%h vld=%b",
                     tag, $time, lane_code, lane_byte, lane_bvld, ec, eb, ev);
        end
    endtask

    // Source model: offers bytes in order, notes what the coming edge takes.
    task automatic feed();
        if (pend) idx++;
        if (idx < n_cur) begin
            src_valid = 1'b1;
            src_data  = pl[idx];
            src_last  = last_en && (idx == n_cur - 1);
        end else begin
            src_valid = 1'b0;
            src_data  = '0;
            src_last  = 1'b0;
        end
        pend = src_ready && src_valid;
    endtask

    task automatic step(string tag, logic [1:0] ec, logic [DW-1:0] eb, logic ev);
        @(negedge clk);
        check(tag, ec, eb, ev);
        feed();
    endtask

    task automatic run_burst(int lpx, int prep, int zero, int trl, int ext,
                             int n, bit use_last, bit nag);
        logic lb;
        cfg_lpx = CW'(lpx); cfg_prep = CW'(prep); cfg_zero = CW'(zero);
        cfg_trail = CW'(trl); cfg_exit = CW'(ext);
        n_cur = n; last_en = use_last; idx = 0; pend = 1'b0;
        for (int k = 0; k < n; k++) pl[k] = DW'($urandom);
        @(negedge clk);
        start = 1'b1; clk_rdy = 1'b1; src_valid = 1'b0;
        for (int i = 0; i < span(lpx); i++) begin
            step("R3 request", C_REQ, '0, 1'b0);
            start = 1'b0;
        end
        for (int i = 0; i < span(prep); i++) step("R3 bridge", C_BRG, '0, 1'b0);
        for (int i = 0; i < span(zero); i++) step("R4 zero", C_HS, '0, 1'b1);
        step("R4 sync", C_HS, SYNC_B, 1'b1);
        for (int k = 0; k < n; k++) step("R5 payload", C_HS, pl[k], 1'b1);
        lb = (n > 0) ? pl[n-1][DW-1] : SYNC_B[DW-1];
        if (nag) start = 1'b1;  // R8: start must be ignored in trail and exit
        for (int i = 0; i < span(trl); i++) step("R6/R7 trail", C_HS, trail_fill(lb), 1'b1);
        for (int i = 0; i < span(ext); i++) begin
            step("R8 exit", C_STOP, '0, 1'b0);
            if (i == span(ext) - 1) start = 1'b0;
        end
        step("R8 idle after exit", C_STOP, '0, 1'b0);
        step("R9 idle quiet", C_STOP, '0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog R1..all actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start = 1'b0; clk_rdy = 1'b0;
        src_valid = 1'b0; src_data = '0; src_last = 1'b0;
        cfg_lpx = '0; cfg_prep = '0; cfg_zero = '0; cfg_trail = '0; cfg_exit = '0;
        idx = 0; n_cur = 0; pend = 1'b0; last_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 reset", C_STOP, '0, 1'b0);
        checks++;
        if (src_ready !== 1'b0) begin
            fails++;
            $display("FAIL R1 ready actual=%b expected=0", src_ready);
        end

        // R2: start without the clock lane ready is ignored
        start = 1'b1; clk_rdy = 1'b0;
        for (int i = 0; i < 4; i++) step("R2 no clk_rdy", C_STOP, '0, 1'b0);
        start = 1'b0; clk_rdy = 1'b1;
        for (int i = 0; i < 2; i++) step("R2 no start", C_STOP, '0, 1'b0);

        // Directed corners
        run_burst(2, 3, 2, 3, 4, 3, 1'b1, 1'b0);   // R6 last-flag end
        run_burst(0, 0, 0, 0, 0, 2, 1'b0, 1'b1);   // zero counts clamp, R6 underrun, R8 start held
        run_burst(1, 1, 1, 2, 2, 0, 1'b1, 1'b0);   // R7 no payload: trail from sync byte
        run_burst(3, 2, 4, 1, 5, 1, 1'b1, 1'b1);

        // Random bursts
        for (int t = 0; t < 40; t++) begin
            run_burst(int'($urandom_range(0, 6)), int'($urandom_range(0, 6)),
                      int'($urandom_range(0, 6)), int'($urandom_range(0, 6)),
                      int'($urandom_range(0, 6)), int'($urandom_range(0, 12)),
                      1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule